// File: doc/BRIEF.md
# Timed Audio Sample Fetch Channel

The block is a paced byte-streaming DMA channel for audio. Software writes a 20-bit start address, a 20-bit byte count and a control byte through a byte-wide register port. Once enabled, the channel turns a 24 kHz base tick into a slower sample rate. On each rate tick it arms one fetch. It reads that byte from memory during a fixed bus-steal slot and hands the byte to one of two audio sinks as a single-cycle valid pulse.

A free-running 128-cycle slot counter sets when the channel may use the bus. A fetch happens only in slot 117. The steal output then covers slots 117 to 123 of that window. The source pointer moves by one byte per fetch, upward or downward. When the count runs out, the channel either stops or restarts from the start address and count it latched when it was enabled. A read that lands in a slow or narrow memory region stops the channel at once.

Top module: `snd_fetch_dma`

## Requirements
- R1: Register offsets: 0, 1 and 2 hold the start address bytes (low, middle, high; the high byte uses bits 3:0). Offsets 3, 4 and 5 hold the byte count in the same order. Offset 6 is control: bit 7 enable, bit 6 direction, bit 4 target, bit 3 repeat, bits 1:0 rate. Control bits 5 and 2 always read back as 0.
- R2: After reset, every register reads 0, and mem_req, bus_steal, ch_valid and voice_valid are low.
- R3: Rate codes 0, 1, 2 and 3 produce one sample per 1, 2, 4 or 6 base ticks. The divider restarts whenever enable goes from 0 to 1.
- R4: The slot counter is 0 in the first cycle after reset and wraps at 128. mem_req is raised only in slot 117 while a sample is pending. The fetched byte appears on the selected sink's data port with a one-cycle valid in the next cycle.
- R5: bus_steal is high for exactly slots 117 to 123 of each window in which a fetch is attempted. It is low at all other times.
- R6: Each fetch moves the source address by +1 when direction is 0, or by -1 when direction is 1.
- R7: Target 0 drives ch_valid/ch_data and target 1 drives voice_valid/voice_data. The other valid output stays low.
- R8: With repeat 0, the enable bit clears after the byte that brings the count to zero. Later ticks produce no sample.
- R9: With repeat 1, the address and count reload from the start registers after the last byte, and streaming continues.
- R10: If mem_slow is high during the fetch cycle, no sample is delivered, the enable bit clears and nothing further is fetched.
- R11: Base ticks while the channel is disabled produce no fetch and no sample. At most one sample is pending at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| base_tick | input | 1 | One-cycle pulse at the 24 kHz base rate |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | 20 | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid in the request cycle |
| mem_slow | input | 1 | Addressed region is narrow or wait-stated |
| bus_steal | output | 1 | Channel owns the bus |
| ch_valid | output | 1 | Sample strobe to the sound-channel sink |
| ch_data | output | 8 | Sample byte to the sound-channel sink |
| voice_valid | output | 1 | Sample strobe to the voice sink |
| voice_data | output | 8 | Sample byte to the voice sink |

## Verification
The bench uses the default parameters: 20-bit address and count, a 7-bit slot counter and a 7-cycle window starting at slot 117. Base ticks are spaced 300 cycles apart, which is more than two windows. Every armed fetch therefore completes before the next tick, and the number of samples after twelve ticks shows the divisor exactly. A start address just below the slow region, plus 3-byte counts, brings the abort path, one-shot stop and repeat reload within a few dozen ticks.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;
    localparam int CTL_EN  = 7;
    localparam int CTL_DIR = 6;
    localparam int CTL_TGT = 4;
    localparam int CTL_REP = 3;

    typedef enum logic [2:0] {
        OFS_SRC0 = 3'd0,
        OFS_SRC1 = 3'd1,
        OFS_SRC2 = 3'd2,
        OFS_LEN0 = 3'd3,
        OFS_LEN1 = 3'd4,
        OFS_LEN2 = 3'd5,
        OFS_CTRL = 3'd6
    } reg_ofs_e;

    function automatic logic [2:0] rate_divisor(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd6;
        endcase
    endfunction
endpackage

// File: rtl/snd_slot_timer.sv
module snd_slot_timer #(
    parameter int SLOT_BITS = 7,
    parameter int WIN_START = 117,
    parameter int WIN_LEN   = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [SLOT_BITS-1:0] slot,
    output logic                 win_first,
    output logic                 win_last,
    output logic                 in_win
);
    localparam logic [SLOT_BITS-1:0] FIRST = SLOT_BITS'(WIN_START);
    localparam logic [SLOT_BITS-1:0] LAST  = SLOT_BITS'(WIN_START + WIN_LEN - 1);

    logic [SLOT_BITS-1:0] slot_d, slot_q;

    always_comb slot_d = slot_q + SLOT_BITS'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign slot      = slot_q;
    assign win_first = (slot_q == FIRST);
    assign win_last  = (slot_q == LAST);
    assign in_win    = (slot_q >= FIRST) && (slot_q <= LAST);
endmodule

// File: rtl/snd_rate_pacer.sv
module snd_rate_pacer
    import snd_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic       restart,
    input  logic [1:0] rate_sel,
    output logic       rate_tick
);
    logic [2:0] cnt_d, cnt_q;
    logic [2:0] last;

    always_comb begin
        last      = rate_divisor(rate_sel) - 3'd1;
        cnt_d     = cnt_q;
        rate_tick = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (base_tick) begin
            if (cnt_q >= last) begin
                cnt_d     = '0;
                rate_tick = 1'b1;
            end else begin
                cnt_d = cnt_q + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/snd_fetch_dma.sv
module snd_fetch_dma
    import snd_dma_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int LEN_W     = 20,
    parameter int SLOT_BITS = 7,
    parameter int WIN_START = 117,
    parameter int WIN_LEN   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              base_tick,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_slow,
    output logic              bus_steal,
    output logic              ch_valid,
    output logic [7:0]        ch_data,
    output logic              voice_valid,
    output logic [7:0]        voice_data
);
    localparam int FIELD_W = 24;

    typedef struct packed {
        logic [ADDR_W-1:0] start_addr;
        logic [LEN_W-1:0]  start_len;
        logic [ADDR_W-1:0] cur_addr;
        logic [LEN_W-1:0]  cur_len;
        logic              en;
        logic              dir;
        logic              tgt;
        logic              rep;
        logic [1:0]        rate;
        logic              pending;
        logic              owned;
        logic              ch_v;
        logic              vo_v;
        logic [7:0]        sample;
    } state_t;

    state_t q, d;

    logic [SLOT_BITS-1:0] slot;
    logic win_first, win_last, in_win;
    logic rate_tick, restart, fetch_go;
    logic [FIELD_W-1:0] src_w, len_w, src_n, len_n;

    snd_slot_timer #(
        .SLOT_BITS(SLOT_BITS),
        .WIN_START(WIN_START),
        .WIN_LEN  (WIN_LEN)
    ) i_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (slot),
        .win_first(win_first),
        .win_last (win_last),
        .in_win   (in_win)
    );

    snd_rate_pacer i_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_tick(base_tick),
        .restart  (restart),
        .rate_sel (q.rate),
        .rate_tick(rate_tick)
    );

    assign src_w    = FIELD_W'(q.start_addr);
    assign len_w    = FIELD_W'(q.start_len);
    assign fetch_go = q.en && q.pending && win_first;

    always_comb begin
        src_n = src_w;
        len_n = len_w;
        if (reg_we) begin
            case (reg_addr)
                OFS_SRC0: src_n[7:0]   = reg_wdata;
                OFS_SRC1: src_n[15:8]  = reg_wdata;
                OFS_SRC2: src_n[23:16] = reg_wdata;
                OFS_LEN0: len_n[7:0]   = reg_wdata;
                OFS_LEN1: len_n[15:8]  = reg_wdata;
                OFS_LEN2: len_n[23:16] = reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        d       = q;
        d.ch_v  = 1'b0;
        d.vo_v  = 1'b0;
        restart = 1'b0;

        if (win_last) d.owned = 1'b0;

        if (fetch_go) begin
            d.owned   = 1'b1;
            d.pending = 1'b0;
            if (mem_slow) begin
                d.en = 1'b0;
            end else begin
                d.sample = mem_rdata;
                d.ch_v   = !q.tgt;
                d.vo_v   = q.tgt;
                d.cur_addr = q.dir ? q.cur_addr - ADDR_W'(1) : q.cur_addr + ADDR_W'(1);
                d.cur_len  = q.cur_len - LEN_W'(1);
                if (q.cur_len == LEN_W'(1)) begin
                    if (q.rep) begin
                        d.cur_addr = q.start_addr;
                        d.cur_len  = q.start_len;
                    end else begin
                        d.en = 1'b0;
                    end
                end
            end
        end

        if (q.en && d.en && rate_tick) d.pending = 1'b1;

        d.start_addr = src_n[ADDR_W-1:0];
        d.start_len  = len_n[LEN_W-1:0];

        if (reg_we && reg_addr == OFS_CTRL) begin
            d.dir  = reg_wdata[CTL_DIR];
            d.tgt  = reg_wdata[CTL_TGT];
            d.rep  = reg_wdata[CTL_REP];
            d.rate = reg_wdata[1:0];
            if (!reg_wdata[CTL_EN]) begin
                d.en      = 1'b0;
                d.pending = 1'b0;
            end else if (!q.en) begin
                d.en       = 1'b1;
                d.pending  = 1'b0;
                d.cur_addr = q.start_addr;
                d.cur_len  = q.start_len;
                restart    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            OFS_SRC0: reg_rdata = src_w[7:0];
            OFS_SRC1: reg_rdata = src_w[15:8];
            OFS_SRC2: reg_rdata = src_w[23:16];
            OFS_LEN0: reg_rdata = len_w[7:0];
            OFS_LEN1: reg_rdata = len_w[15:8];
            OFS_LEN2: reg_rdata = len_w[23:16];
            OFS_CTRL: reg_rdata = {q.en, q.dir, 1'b0, q.tgt, q.rep, 1'b0, q.rate};
            default:  reg_rdata = 8'h00;
        endcase
    end

    assign mem_req     = fetch_go;
    assign mem_addr    = q.cur_addr;
    assign bus_steal   = fetch_go || (q.owned && in_win);
    assign ch_valid    = q.ch_v;
    assign voice_valid = q.vo_v;
    assign ch_data     = q.ch_v ? q.sample : 8'h00;
    assign voice_data  = q.vo_v ? q.sample : 8'h00;
endmodule

// File: rtl/snd_fetch_dma_chk.sv
module snd_fetch_dma_chk #(
    parameter int SLOT_BITS = 7,
    parameter int WIN_START = 117,
    parameter int WIN_LEN   = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [SLOT_BITS-1:0] slot,
    input logic                 mem_req,
    input logic                 bus_steal,
    input logic                 ch_valid,
    input logic                 voice_valid
);
    localparam logic [SLOT_BITS-1:0] FIRST = SLOT_BITS'(WIN_START);
    localparam logic [SLOT_BITS-1:0] LAST  = SLOT_BITS'(WIN_START + WIN_LEN - 1);

    assert_req_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (slot == FIRST));

    assert_req_steal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> bus_steal);

    assert_steal_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_steal |-> (slot >= FIRST && slot <= LAST));

    assert_steal_contiguous_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_steal && slot != FIRST) |-> $past(bus_steal));

    assert_sample_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid || voice_valid) |-> $past(mem_req));

    assert_one_sink_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_valid, voice_valid}));
endmodule

bind snd_fetch_dma snd_fetch_dma_chk #(
    .SLOT_BITS(SLOT_BITS),
    .WIN_START(WIN_START),
    .WIN_LEN  (WIN_LEN)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot       (slot),
    .mem_req    (mem_req),
    .bus_steal  (bus_steal),
    .ch_valid   (ch_valid),
    .voice_valid(voice_valid)
);

// File: tb/test_snd_fetch_dma.sv
module test_snd_fetch_dma;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic base_tick = 1'b0;
    logic mem_req;
    logic [19:0] mem_addr;
    logic [7:0] mem_rdata;
    logic mem_slow;
    logic bus_steal, ch_valid, voice_valid;
    logic [7:0] ch_data, voice_data;

    int checks = 0;
    int fails = 0;
    int steal_cycles = 0;
    int req_count = 0;
    int samples = 0;
    logic [6:0] bslot = '0;
    logic [8:0] sb_q[$];

    always #4 clk = ~clk;

    snd_fetch_dma i_snd_fetch_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .base_tick(base_tick),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_slow(mem_slow), .bus_steal(bus_steal), .ch_valid(ch_valid),
        .ch_data(ch_data), .voice_valid(voice_valid), .voice_data(voice_data)
    );

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h5, a[19:16]};
    endfunction

    assign mem_rdata = mem_byte(mem_addr);
    assign mem_slow  = mem_addr[19];

    always @(posedge clk) begin
        if (!rst_n) bslot <= '0;
        else        bslot <= bslot + 7'd1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard pop plus slot discipline at the ports
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_steal) steal_cycles++;
            if (mem_req) begin
                req_count++;
                if (bslot != 7'd117) check("R4 mem_req slot", 32'(bslot), 32'd117);
            end
            if (bus_steal && (bslot < 7'd117 || bslot > 7'd123))
                check("R5 steal outside window", 32'(bslot), 32'd117);
            if (ch_valid || voice_valid) begin
                samples++;
                if (sb_q.size() == 0) begin
                    check("R11 unexpected sample", {23'd0, voice_valid, voice_valid ? voice_data : ch_data}, 32'h1ff);
                end else begin
                    logic [8:0] e;
                    e = sb_q.pop_front();
                    check("R7 sample target/data", {23'd0, voice_valid, voice_valid ? voice_data : ch_data},
                          {23'd0, e});
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic setup(input logic [19:0] src, input logic [19:0] len);
        wr(3'd0, src[7:0]); wr(3'd1, src[15:8]); wr(3'd2, {4'h0, src[19:16]});
        wr(3'd3, len[7:0]); wr(3'd4, len[15:8]); wr(3'd5, {4'h0, len[19:16]});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            repeat (299) @(negedge clk);
            base_tick = 1'b1;
            @(negedge clk);
            base_tick = 1'b0;
        end
        repeat (300) @(negedge clk);
    endtask

    // driver: pushes expected bytes for a run starting at src
    task automatic expect_run(input logic [19:0] src, input int n, input logic dec, input logic tgt);
        for (int i = 0; i < n; i++) begin
            logic [19:0] a;
            a = dec ? src - 20'(i) : src + 20'(i);
            sb_q.push_back({tgt, mem_byte(a)});
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        #1;
        check("R2 outputs idle", {28'd0, mem_req, bus_steal, ch_valid, voice_valid}, 32'd0);
        rd(3'd6, 8'h00, "R2 control after reset");
        rd(3'd3, 8'h00, "R2 length after reset");

        // R1 register map
        setup(20'h51234, 20'h00064);
        rd(3'd0, 8'h34, "R1 source low");
        rd(3'd2, 8'h05, "R1 source high");
        rd(3'd3, 8'h64, "R1 length low");
        wr(3'd6, 8'h7F);
        rd(3'd6, 8'h5B, "R1 control bits 5,2 read 0");

        // R3 / R6 / R7: increment, sound channel, each rate code
        setup(20'h01000, 20'd100);
        for (int r = 0; r < 4; r++) begin
            int div;
            div = (r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 4 : 6;
            wr(3'd6, 8'h00);
            base = samples;
            expect_run(20'h01000, 12 / div, 1'b0, 1'b0);
            wr(3'd6, 8'h80 | 8'(r));
            ticks(12);
            check("R3 samples per rate code", 32'(samples - base), 32'(12 / div));
        end
        wr(3'd6, 8'h00);

        // R8 / R6 / R7: decrement, voice, one-shot of 3 bytes
        setup(20'h02010, 20'd3);
        base = samples;
        expect_run(20'h02010, 3, 1'b1, 1'b1);
        wr(3'd6, 8'hD0);
        ticks(5);
        check("R8 one-shot sample count", 32'(samples - base), 32'd3);
        rd(3'd6, 8'h50, "R8 enable cleared after count");

        // R9 repeat: 7 ticks over a 3-byte loop
        setup(20'h03000, 20'd3);
        base = samples;
        expect_run(20'h03000, 3, 1'b0, 1'b0);
        expect_run(20'h03000, 3, 1'b0, 1'b0);
        expect_run(20'h03000, 1, 1'b0, 1'b0);
        wr(3'd6, 8'h88);
        ticks(7);
        check("R9 repeat sample count", 32'(samples - base), 32'd7);
        rd(3'd6, 8'h88, "R9 still enabled");
        wr(3'd6, 8'h00);

        // R10 slow region abort at 0x80000
        setup(20'h7FFFE, 20'd5);
        base = samples;
        expect_run(20'h7FFFE, 2, 1'b0, 1'b0);
        wr(3'd6, 8'h80);
        ticks(4);
        check("R10 samples before abort", 32'(samples - base), 32'd2);
        rd(3'd6, 8'h00, "R10 enable cleared by abort");

        // R11 ticks while disabled
        base = req_count;
        ticks(3);
        check("R11 no fetch while disabled", 32'(req_count - base), 32'd0);

        // R5 whole-run window accounting, scoreboard drained
        check("R5 seven steal cycles per fetch", 32'(steal_cycles), 32'(7 * req_count));
        check("R4 scoreboard drained", 32'(sb_q.size()), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule